// File: doc/BRIEF.md
# Dual-Output Compare PWM Stage

This block generates two pulse-width-modulated outputs, A and B, from one shared up/down counter. Each output has its own pair of compare values: a start value that drives the output high and a stop value that drives it low. A period register sets the counter's top value. The counter runs in one of two shapes, chosen by a configuration input. In single-ramp mode it counts up from 0 to the top value and wraps, so the edges of the outputs line up with the start of the cycle. In centered mode it falls from the top value to 0, holds there for one extra clock, then climbs back to the top value. The pulses are then placed symmetrically about the counter's minimum. With the same period value, a centered cycle lasts exactly twice as long as a single-ramp cycle.

Software-side writes go through a small write port into shadow copies of the period and compare values. The shadow copies, together with the mode input, move into the active set only on the clock edge that ends a cycle. While the block is disabled they move on every clock. An update-lock input holds the active set so that several values can be changed without a partial update. A one-clock end-of-cycle pulse marks each edge on which the active set is reloaded during operation.

Top module: `pwm2_dual`

## Requirements
- R1: While `rst` is high or `en` is low, the counter is held at 0 and `pwm_a`, `pwm_b` and `cyc_end` are low from the next clock on.
- R2: In single-ramp mode the counter steps 0, 1, ..., top and then back to 0, so one cycle lasts top+1 clocks (1 clock when top is 0).
- R3: In centered mode the counter steps top, top-1, ..., 0, holds 0 for one more clock, and then steps 1, ..., top. One cycle lasts 2*(top+1) clocks, twice the single-ramp length for the same top.
- R4: In single-ramp mode each output register goes high on the clock after the counter equals the output's start value. It goes low on the clock after the counter equals its stop value. If the two values are equal, the output goes low.
- R5: In centered mode each output register is high on the clock after a falling-phase count below its start value, or after a rising-phase count below its stop value. Otherwise it is low.
- R6: A write with `wr_en` high stores `wr_data` in the shadow value chosen by `wr_sel`: 0 period, 1 A start, 2 A stop, 3 B start, 4 B stop. Selectors 5 to 7 change nothing.
- R7: While enabled, shadow values and the `cfg_center` mode take effect only on the clock edge that ends the current cycle. A mid-cycle period write leaves the length of the running cycle unchanged.
- R8: While `upd_lock` is high, the active period, compare values and mode do not change, either at a cycle end or while disabled.
- R9: `cyc_end` is high for one clock after each end-of-cycle edge while enabled. After that edge the counter reads 0 in single-ramp mode, and reads the top value while falling in centered mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Runs the counter when high |
| cfg_center | input | 1 | Mode for the next cycle: 1 centered, 0 single-ramp |
| upd_lock | input | 1 | Holds the active set when high |
| wr_en | input | 1 | Shadow register write strobe |
| wr_sel | input | 3 | Shadow register selector |
| wr_data | input | CNT_W | Write data |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| cyc_end | output | 1 | One-clock pulse after each cycle-end reload |

## Verification
The bench builds the block with its default 12-bit counter. It programs small period values, down to 0, so that many complete cycles and every mode switch fit in a short run. This brings within reach the one-clock single-ramp cycle, the two-clock centered cycle, and the hold at the bottom of the centered ramp. The bench also covers reloads that coincide with a write or a lock, and a start value equal to its stop value. A behavioural model predicts both outputs and the end-of-cycle pulse on every clock. Period measurements taken between pulses check cycle lengths and the timing of reloads.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;

    localparam int NUM_SEL = 5;
    localparam int SEL_W   = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_TOP   = 3'd0,
        SEL_A_SET = 3'd1,
        SEL_A_CLR = 3'd2,
        SEL_B_SET = 3'd3,
        SEL_B_CLR = 3'd4
    } sel_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    function automatic int set_index(input int ch);
        return int'(SEL_A_SET) + 2 * ch;
    endfunction

    function automatic int clr_index(input int ch);
        return int'(SEL_A_CLR) + 2 * ch;
    endfunction

endpackage

// File: rtl/pwm2_regs.sv
module pwm2_regs
    import pwm2_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [SEL_W-1:0]                wr_sel,
    input  logic [CNT_W-1:0]                wr_data,
    input  logic                            cfg_center,
    input  logic                            load,
    output logic [NUM_SEL-1:0][CNT_W-1:0]   act_vals,
    output logic                            act_center,
    output logic [NUM_SEL-1:0][CNT_W-1:0]   nxt_vals,
    output logic                            nxt_center
);

    logic [NUM_SEL-1:0][CNT_W-1:0] shadow;

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_shadow
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow[i] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(i))) begin
                shadow[i] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_vals   <= '0;
            act_center <= 1'b0;
        end else if (load) begin
            act_vals   <= shadow;
            act_center <= cfg_center;
        end
    end

    always_comb begin
        nxt_vals   = load ? shadow     : act_vals;
        nxt_center = load ? cfg_center : act_center;
    end

    // R8: no reload request, active set unchanged
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !load |=> (act_vals == $past(act_vals)) && (act_center == $past(act_center)));

endmodule

// File: rtl/pwm2_counter.sv
module pwm2_counter
    import pwm2_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] top,
    input  logic             center,
    input  logic [CNT_W-1:0] nxt_top,
    input  logic             nxt_center,
    output logic [CNT_W-1:0] cnt,
    output dir_e             dir,
    output logic             at_end,
    output logic             eoc
);

    always_comb begin
        if (center) begin
            at_end = (dir == DIR_UP) && (cnt == top);
        end else begin
            at_end = (cnt == top);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            dir <= DIR_UP;
            eoc <= 1'b0;
        end else begin
            eoc <= at_end;
            if (at_end) begin
                if (nxt_center) begin
                    cnt <= nxt_top;
                    dir <= DIR_DOWN;
                end else begin
                    cnt <= '0;
                    dir <= DIR_UP;
                end
            end else if (center && (dir == DIR_DOWN)) begin
                if (cnt == '0) begin
                    dir <= DIR_UP;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2: running count never passes the active top
    p_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt <= top));

    // R3: falling phase steps down by one
    p_down_step_r3: assert property (@(posedge clk) disable iff (rst)
        (en && center && (dir == DIR_DOWN) && (cnt != '0)) |=>
            (!en || (cnt == $past(cnt) - 1'b1)));

    // R9: counter position right after a cycle end
    p_eoc_phase_r9: assert property (@(posedge clk) disable iff (rst)
        eoc |-> (center ? ((dir == DIR_DOWN) && (cnt == top)) : (cnt == '0)));

endmodule

// File: rtl/pwm2_chan.sv
module pwm2_chan
    import pwm2_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] cnt,
    input  dir_e             dir,
    input  logic             center,
    input  logic [CNT_W-1:0] set_v,
    input  logic [CNT_W-1:0] clr_v,
    output logic             out
);

    logic out_d;

    always_comb begin
        if (center) begin
            out_d = (dir == DIR_DOWN) ? (cnt < set_v) : (cnt < clr_v);
        end else if (cnt == clr_v) begin
            out_d = 1'b0;
        end else if (cnt == set_v) begin
            out_d = 1'b1;
        end else begin
            out_d = out;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            out <= 1'b0;
        end else begin
            out <= out_d;
        end
    end

    // R1: disabled channel is low on the next clock
    p_off_low_r1: assert property (@(posedge clk) disable iff (rst)
        !en |=> !out);

    // R5: rising phase at or above the stop value gives low
    p_center_fall_r5: assert property (@(posedge clk) disable iff (rst)
        (en && center && (dir == DIR_UP) && (cnt >= clr_v)) |=> !out);

endmodule

// File: rtl/pwm2_dual.sv
module pwm2_dual
    import pwm2_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             cfg_center,
    input  logic             upd_lock,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_a,
    output logic             pwm_b,
    output logic             cyc_end
);

    localparam int NUM_CH = 2;

    logic [NUM_SEL-1:0][CNT_W-1:0] act_vals;
    logic [NUM_SEL-1:0][CNT_W-1:0] nxt_vals;
    logic                          act_center;
    logic                          nxt_center;
    logic                          load;
    logic                          at_end;
    logic [CNT_W-1:0]              cnt;
    dir_e                          dir;
    logic [NUM_CH-1:0]             pwm;

    assign load = !upd_lock && (!en || at_end);

    pwm2_regs #(.CNT_W(CNT_W)) i_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .cfg_center (cfg_center),
        .load       (load),
        .act_vals   (act_vals),
        .act_center (act_center),
        .nxt_vals   (nxt_vals),
        .nxt_center (nxt_center)
    );

    pwm2_counter #(.CNT_W(CNT_W)) i_counter (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .top        (act_vals[SEL_TOP]),
        .center     (act_center),
        .nxt_top    (nxt_vals[SEL_TOP]),
        .nxt_center (nxt_center),
        .cnt        (cnt),
        .dir        (dir),
        .at_end     (at_end),
        .eoc        (cyc_end)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        pwm2_chan #(.CNT_W(CNT_W)) i_chan (
            .clk    (clk),
            .rst    (rst),
            .en     (en),
            .cnt    (cnt),
            .dir    (dir),
            .center (act_center),
            .set_v  (act_vals[set_index(g)]),
            .clr_v  (act_vals[clr_index(g)]),
            .out    (pwm[g])
        );
    end

    assign pwm_a = pwm[0];
    assign pwm_b = pwm[1];

    // R9: pulse only while running
    p_eoc_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
        cyc_end |-> $past(en));

endmodule

// File: tb/test_pwm2_dual.sv
module test_pwm2_dual;

    localparam int CNT_W = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en = 1'b0;
    logic             cfg_center = 1'b0;
    logic             upd_lock = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_sel = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             pwm_a, pwm_b, cyc_end;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    pwm2_dual #(.CNT_W(CNT_W)) i_pwm2_dual (
        .clk(clk), .rst(rst), .en(en), .cfg_center(cfg_center),
        .upd_lock(upd_lock), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b), .cyc_end(cyc_end)
    );

    // behavioural reference: index 0 top, 1 A start, 2 A stop, 3 B start, 4 B stop
    int m_sh[5];
    int m_act[5];
    bit m_ctr = 0;
    int m_cnt = 0;
    bit m_down = 0;
    bit m_oa = 0, m_ob = 0, m_eoc = 0;
    bit started = 0;

    function automatic bit chan_next(bit ctr, bit down, int cnt, int s, int c, bit prev);
        if (ctr) return down ? (cnt < s) : (cnt < c);
        if (cnt == c) return 1'b0;
        if (cnt == s) return 1'b1;
        return prev;
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            foreach (m_sh[i]) begin m_sh[i] = 0; m_act[i] = 0; end
            m_ctr = 0; m_cnt = 0; m_down = 0; m_oa = 0; m_ob = 0; m_eoc = 0;
        end else begin
            bit last, ld;
            int n_act[5];
            bit n_ctr;
            last = m_ctr ? (!m_down && m_cnt == m_act[0]) : (m_cnt == m_act[0]);
            ld = !upd_lock && (!en || last);
            foreach (n_act[i]) n_act[i] = ld ? m_sh[i] : m_act[i];
            n_ctr = ld ? cfg_center : m_ctr;
            if (!en) begin
                m_oa = 0; m_ob = 0; m_eoc = 0; m_cnt = 0; m_down = 0;
            end else begin
                m_oa = chan_next(m_ctr, m_down, m_cnt, m_act[1], m_act[2], m_oa);
                m_ob = chan_next(m_ctr, m_down, m_cnt, m_act[3], m_act[4], m_ob);
                m_eoc = last;
                if (last) begin
                    if (n_ctr) begin m_cnt = n_act[0]; m_down = 1; end
                    else begin m_cnt = 0; m_down = 0; end
                end else if (m_ctr && m_down) begin
                    if (m_cnt == 0) m_down = 0; else m_cnt = m_cnt - 1;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
            if (wr_en && wr_sel < 3'd5) m_sh[wr_sel] = int'(wr_data);
            foreach (n_act[i]) m_act[i] = n_act[i];
            m_ctr = n_ctr;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // every-clock comparison against the model (R4/R5 outputs, R9 pulse)
    always @(negedge clk) begin
        if (started && !done) begin
            chk(m_ctr ? "R5 pwm_a" : "R4 pwm_a", int'(pwm_a), int'(m_oa));
            chk(m_ctr ? "R5 pwm_b" : "R4 pwm_b", int'(pwm_b), int'(m_ob));
            chk("R9 cyc_end", int'(cyc_end), int'(m_eoc));
        end
    end

    task automatic wr(input int sel, input int data);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = CNT_W'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_eoc();
        do @(negedge clk); while (!cyc_end);
    endtask

    task automatic count_to_eoc(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!cyc_end);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n, hi;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset pwm_a", int'(pwm_a), 0);
        chk("R1 reset pwm_b", int'(pwm_b), 0);
        chk("R1 reset cyc_end", int'(cyc_end), 0);

        wr(0, 9); wr(1, 2); wr(2, 6); wr(3, 0); wr(4, 4);
        en = 1'b1;
        wait_eoc(); count_to_eoc(n);
        chk("R2 single period top 9", n, 10);

        wr(5, 1); wr(6, 2); wr(7, 3);
        wait_eoc(); count_to_eoc(n);
        chk("R6 bad selectors leave period", n, 10);

        wait_eoc(); wr(0, 5); count_to_eoc(n);
        chk("R7 mid-cycle write deferred", n + 1, 10);
        count_to_eoc(n);
        chk("R7 new period applied", n, 6);

        upd_lock = 1'b1; wr(0, 3);
        wait_eoc(); wait_eoc(); count_to_eoc(n);
        chk("R8 locked period held", n, 6);
        upd_lock = 1'b0;
        wait_eoc(); count_to_eoc(n);
        chk("R8 unlocked period applied", n, 4);

        cfg_center = 1'b1;
        wait_eoc(); count_to_eoc(n);
        chk("R3 centered period top 3", n, 8);
        count_to_eoc(n);
        chk("R3 centered twice single", n, 2 * 4);

        wr(1, 1); wr(2, 3); wr(3, 3); wr(4, 0);
        repeat (30) @(negedge clk);
        wr(0, 6); wr(1, 4); wr(2, 2); wr(3, 7); wr(4, 7);
        repeat (40) @(negedge clk);

        en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 disabled pwm_a", int'(pwm_a), 0);
        chk("R1 disabled pwm_b", int'(pwm_b), 0);
        chk("R1 disabled cyc_end", int'(cyc_end), 0);
        en = 1'b1;

        wr(0, 0);
        wait_eoc(); wait_eoc(); count_to_eoc(n);
        chk("R3 centered top 0", n, 2);
        cfg_center = 1'b0;
        wait_eoc(); wait_eoc(); count_to_eoc(n);
        chk("R2 single top 0", n, 1);

        wr(0, 7); wr(1, 3); wr(2, 3);
        wait_eoc(); wait_eoc();
        hi = 0;
        repeat (16) begin @(negedge clk); hi += int'(pwm_a); end
        chk("R4 equal start/stop stays low", hi, 0);

        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule